// File: doc/BRIEF.md
# Channel Trigger Router with Scan Sequencer

This block decides, for each of a parameterised set of converter channels, which event asks for a conversion. Every channel holds a 4-bit source code. On each cycle the block looks at the available trigger sources: a one-shot software pulse, a level software trigger, a periodic timer tick and eleven external event lines. Each channel whose selected source is active gets a one-cycle request on its own line of `req`, which goes to a downstream arbiter.

One code value places a channel in the scan group. A separate scan source code chooses the event that starts a scan. A scan walks the group members that are also set in the scan-include mask. It starts at the lowest index and issues one request at a time, and it waits for `conv_done` before it moves to the next member. At the end of a scan, or at once when the scan has no members, the sticky `eos_flag` is raised. It stays high until `eos_clr` is pulsed.

Configuration is loaded through `cfg_we` and takes effect only while `enable` is low. Lowering `enable` silences every request and drops any scan that is in progress.

The scan sequencer has three states. IDLE waits for a scan trigger. ISSUE drives the request for the lowest pending member and removes that member from the pending set. WAIT holds until `conv_done` is seen. The transitions are:
- IDLE to ISSUE: the trigger arrives and the scan has at least one member.
- IDLE to IDLE: the trigger arrives and the scan is empty. The flag is set.
- ISSUE to WAIT: always.
- WAIT to ISSUE: `conv_done` arrives and members are still pending.
- WAIT to IDLE: `conv_done` arrives and no members are pending. The flag is set.
- Any state to IDLE: `enable` is low.

Top module: `trig_route`

## Requirements
- R1: A channel whose code (bits [4k+3:4k] of `cfg_src`) is 0000 never has its `req` bit asserted.
- R2: Code 0001 routes `sw_pulse`, code 0100 routes `sync_tick`, and code 0101+e routes `evt[e]` (e = 0..10). When a source is active in a cycle, exactly the channels that select it assert `req` in the following cycle, for one cycle.
- R3: Code 0010 makes the channel assert `req` in every cycle after a cycle in which `sw_level` is high. Requests stop in the cycle after `sw_level` falls.
- R4: A scan includes only the channels whose code is 0011 and whose `cfg_mask` bit k is 1. Channels with code 0011 never respond to direct sources.
- R5: A scan requests its members one at a time in ascending index order. The first request appears two cycles after the trigger. Each later request appears two cycles after the `conv_done` that ends the previous one.
- R6: If a scan trigger fires while the scan has no members, `eos_flag` is set in the next cycle and `scan_busy` stays low.
- R7: `eos_flag` rises in the cycle after the last member's `conv_done`. It then stays high until `eos_clr` is sampled high. A set and a clear in the same cycle leave the flag high.
- R8: A scan trigger that arrives while `scan_busy` is high is ignored and does not start another scan later.
- R9: The scan source code (`cfg_scan`) uses the channel layout for codes 0001, 0010, 0100 and 0101..1111. Codes 0000 and 0011 never start a scan.
- R10: `cfg_we` loads configuration only while `enable` is low. While `enable` is low, `req` is zero and any scan is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; configuration is writable only when low |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_src | input | 64 | Per-channel source codes, channel k at bits [4k+3:4k] |
| cfg_scan | input | 4 | Scan trigger source code |
| cfg_mask | input | 16 | Scan-include mask, bit k for channel k |
| sw_pulse | input | 1 | One-shot software trigger |
| sw_level | input | 1 | Level software trigger |
| sync_tick | input | 1 | Timer trigger pulse |
| evt | input | 11 | External event lines |
| conv_done | input | 1 | Conversion-complete pulse from the converter side |
| eos_clr | input | 1 | Write-one-to-clear for the end-of-scan flag |
| req | output | 16 | Per-channel conversion request |
| scan_busy | output | 1 | A scan is in progress |
| eos_flag | output | 1 | Sticky end-of-scan flag |

## Verification
Random code sets that contain no scan codes are run against random patterns of pulse, level, tick and event inputs. These runs show whether each source reaches only the channels that select it and whether the disabled code stays silent. Directed scan runs use a group in which some code-0011 channels are unmasked and some masked channels have other codes. This separates the inclusion rule from each half of it and exposes any wrong ordering. Further directed cases cover:
- triggers that arrive while busy,
- an empty scan with a simultaneous clear,
- the reserved scan source,
- a write made while enabled,
- enable dropped during a scan.

Each of these isolates one rule.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] SRC_NONE  = 4'd0;
    localparam logic [CODE_W-1:0] SRC_SWP   = 4'd1;
    localparam logic [CODE_W-1:0] SRC_SWL   = 4'd2;
    localparam logic [CODE_W-1:0] SRC_SCAN  = 4'd3;
    localparam logic [CODE_W-1:0] SRC_SYNC  = 4'd4;
    localparam logic [CODE_W-1:0] SRC_EVT0  = 4'd5;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_WAIT  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/trig_route_cfg.sv
module trig_route_cfg #(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_we,
    input  logic [NCH*CW-1:0] cfg_src,
    input  logic [CW-1:0]     cfg_scan,
    input  logic [NCH-1:0]    cfg_mask,
    output logic [NCH*CW-1:0] src_q,
    output logic [CW-1:0]     scan_q,
    output logic [NCH-1:0]    mask_q
);
    // Loads are honoured only while the block is disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            scan_q <= '0;
            mask_q <= '0;
        end else if (cfg_we && !enable) begin
            src_q  <= cfg_src;
            scan_q <= cfg_scan;
            mask_q <= cfg_mask;
        end
    end
endmodule

// File: rtl/trig_route_scan.sv
module trig_route_scan
    import trig_route_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           fire,
    input  logic [NCH-1:0] members,
    input  logic           conv_done,
    input  logic           eos_clr,
    output logic [NCH-1:0] scan_req,
    output logic           busy,
    output logic           eos_flag
);
    scan_state_e    state_q, state_d;
    logic [NCH-1:0] pend_q, pend_d;
    logic [NCH-1:0] lowest;
    logic           eos_set;

    assign lowest = pend_q & (~pend_q + {{(NCH-1){1'b0}}, 1'b1});

    // next-state logic
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        eos_set  = 1'b0;
        scan_req = '0;
        if (!enable) begin
            state_d = SC_IDLE;
            pend_d  = '0;
        end else begin
            unique case (state_q)
                SC_IDLE: begin
                    if (fire) begin
                        if (members == '0) begin
                            eos_set = 1'b1;
                        end else begin
                            pend_d  = members;
                            state_d = SC_ISSUE;
                        end
                    end
                end
                SC_ISSUE: begin
                    scan_req = lowest;
                    pend_d   = pend_q & ~lowest;
                    state_d  = SC_WAIT;
                end
                SC_WAIT: begin
                    if (conv_done) begin
                        if (pend_q == '0) begin
                            eos_set = 1'b1;
                            state_d = SC_IDLE;
                        end else begin
                            state_d = SC_ISSUE;
                        end
                    end
                end
                default: state_d = SC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eos_flag <= 1'b0;
        end else if (eos_set) begin
            eos_flag <= 1'b1;
        end else if (eos_clr) begin
            eos_flag <= 1'b0;
        end
    end

    assign busy = (state_q != SC_IDLE);
endmodule

// File: rtl/trig_route.sv
module trig_route
    import trig_route_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NEVT = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  cfg_we,
    input  logic [NCH*CODE_W-1:0] cfg_src,
    input  logic [CODE_W-1:0]     cfg_scan,
    input  logic [NCH-1:0]        cfg_mask,
    input  logic                  sw_pulse,
    input  logic                  sw_level,
    input  logic                  sync_tick,
    input  logic [NEVT-1:0]       evt,
    input  logic                  conv_done,
    input  logic                  eos_clr,
    output logic [NCH-1:0]        req,
    output logic                  scan_busy,
    output logic                  eos_flag
);
    localparam int NSRC = 1 << CODE_W;

    logic [NCH*CODE_W-1:0] src_q;
    logic [CODE_W-1:0]     scan_q;
    logic [NCH-1:0]        mask_q;
    logic [NSRC-1:0]       src_vec;
    logic [NCH-1:0]        direct;
    logic [NCH-1:0]        members;
    logic [NCH-1:0]        scan_req;
    logic                  scan_fire;

    trig_route_cfg #(.NCH(NCH), .CW(CODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cfg_we   (cfg_we),
        .cfg_src  (cfg_src),
        .cfg_scan (cfg_scan),
        .cfg_mask (cfg_mask),
        .src_q    (src_q),
        .scan_q   (scan_q),
        .mask_q   (mask_q)
    );

    // Source vector indexed by code; the none and scan slots stay zero.
    always_comb begin
        src_vec                          = '0;
        src_vec[SRC_SWP]                 = sw_pulse;
        src_vec[SRC_SWL]                 = sw_level;
        src_vec[SRC_SYNC]                = sync_tick;
        src_vec[SRC_EVT0 +: NEVT]        = evt;
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chan
            logic [CODE_W-1:0] code;
            assign code       = src_q[k*CODE_W +: CODE_W];
            assign direct[k]  = (code != SRC_SCAN) && src_vec[code];
            assign members[k] = (code == SRC_SCAN) && mask_q[k];
        end
    endgenerate

    assign scan_fire = src_vec[scan_q];

    trig_route_scan #(.NCH(NCH)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .fire      (scan_fire),
        .members   (members),
        .conv_done (conv_done),
        .eos_clr   (eos_clr),
        .scan_req  (scan_req),
        .busy      (scan_busy),
        .eos_flag  (eos_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            req <= enable ? (direct | scan_req) : '0;
        end
    end
endmodule

// File: rtl/trig_route_chk.sv
module trig_route_chk #(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              eos_clr,
    input logic              eos_flag,
    input logic [NCH-1:0]    req,
    input logic [NCH-1:0]    scan_req,
    input logic [NCH*CW-1:0] src_q
);
    logic [NCH-1:0] zero_mask;
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            zero_mask[k] = (src_q[k*CW +: CW] == '0);
        end
    end

    p_zero_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req & zero_mask) == '0);

    p_scan_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_req));

    p_eos_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eos_flag && !eos_clr |=> eos_flag);

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(src_q));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> req == '0);
endmodule

bind trig_route trig_route_chk #(.NCH(NCH), .CW(trig_route_pkg::CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .eos_clr  (eos_clr),
    .eos_flag (eos_flag),
    .req      (req),
    .scan_req (scan_req),
    .src_q    (src_q)
);

// File: tb/trig_route_bench.sv
module trig_route_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int NEVT = 11;

    logic clk = 1'b0;
    logic rst_n, enable, cfg_we;
    logic [NCH*4-1:0] cfg_src;
    logic [3:0] cfg_scan;
    logic [NCH-1:0] cfg_mask;
    logic sw_pulse, sw_level, sync_tick, conv_done, eos_clr;
    logic [NEVT-1:0] evt;
    logic [NCH-1:0] req;
    logic scan_busy, eos_flag;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_route u_trig_route (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_src(cfg_src), .cfg_scan(cfg_scan), .cfg_mask(cfg_mask),
        .sw_pulse(sw_pulse), .sw_level(sw_level), .sync_tick(sync_tick),
        .evt(evt), .conv_done(conv_done), .eos_clr(eos_clr),
        .req(req), .scan_busy(scan_busy), .eos_flag(eos_flag)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        sw_pulse = 0; sw_level = 0; sync_tick = 0; evt = '0;
        conv_done = 0; eos_clr = 0; cfg_we = 0;
    endtask

    task automatic load(input logic [NCH*4-1:0] s, input logic [3:0] sc, input logic [NCH-1:0] m);
        enable = 0; cfg_we = 1; cfg_src = s; cfg_scan = sc; cfg_mask = m;
        cyc();
        cfg_we = 0; enable = 1;
    endtask

    function automatic logic [NCH-1:0] exp_req(input logic [NCH*4-1:0] codes, input logic p,
                                               input logic l, input logic t, input logic [NEVT-1:0] e);
        logic [NCH-1:0] r;
        for (int k = 0; k < NCH; k++) begin
            logic [3:0] c;
            c = codes[k*4 +: 4];
            if (c == 4'd1) r[k] = p;
            else if (c == 4'd2) r[k] = l;
            else if (c == 4'd4) r[k] = t;
            else if (c >= 4'd5) r[k] = e[c - 4'd5];
            else r[k] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [NCH*4-1:0] put(input logic [NCH*4-1:0] v, input int ch, input logic [3:0] c);
        logic [NCH*4-1:0] r;
        r = v;
        r[ch*4 +: 4] = c;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NCH*4-1:0] codes;
        void'($urandom(32'h5eed));
        idle_in();
        rst_n = 0; enable = 0; cfg_src = '0; cfg_scan = '0; cfg_mask = '0;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        chk("R10 reset req", 32'(req), 0);
        chk("R7 reset eos", 32'(eos_flag), 0);
        chk("R5 reset busy", 32'(scan_busy), 0);

        // R1 R2 boundary events and timer
        codes = '0;
        codes = put(codes, 0, 4'd15);
        codes = put(codes, 15, 4'd5);
        codes = put(codes, 3, 4'd4);
        load(codes, 4'd0, '0);
        evt[10] = 1; cyc(); evt = '0;
        chk("R2 evt10 to ch0", 32'(req), 32'h0001);
        evt[0] = 1; cyc(); evt = '0;
        chk("R2 evt0 to ch15", 32'(req), 32'h8000);
        sync_tick = 1; cyc(); sync_tick = 0;
        chk("R2 timer to ch3", 32'(req), 32'h0008);
        cyc();
        chk("R2 one cycle only", 32'(req), 0);

        // random routing, no scan codes
        for (int it = 0; it < 150; it++) begin
            codes = '0;
            for (int k = 0; k < NCH; k++) begin
                logic [3:0] c;
                c = 4'($urandom_range(0, 15));
                if (c == 4'd3) c = 4'd0;
                codes = put(codes, k, c);
            end
            load(codes, 4'd0, 16'($urandom));
            for (int j = 0; j < 20; j++) begin
                logic [NCH-1:0] e;
                sw_pulse = 1'($urandom); sw_level = 1'($urandom);
                sync_tick = 1'($urandom); evt = 11'($urandom);
                e = exp_req(codes, sw_pulse, sw_level, sync_tick, evt);
                cyc();
                chk("R1 R2 R3 random routing", 32'(req), 32'(e));
            end
            idle_in();
        end

        // R3 level trigger
        codes = put('0, 7, 4'd2);
        load(codes, 4'd0, '0);
        sw_level = 1;
        for (int j = 0; j < 3; j++) begin
            cyc();
            chk("R3 level held", 32'(req), 32'h0080);
        end
        sw_level = 0; cyc();
        chk("R3 level released", 32'(req), 0);

        // R10 write while enabled is ignored
        cfg_we = 1; cfg_src = put('0, 7, 4'd1); cyc(); cfg_we = 0;
        sw_level = 1; cyc(); sw_level = 0;
        chk("R10 write while enabled ignored", 32'(req), 32'h0080);

        // R4 R5 R7 R8 scan
        codes = '0;
        codes = put(codes, 2, 4'd3);
        codes = put(codes, 5, 4'd3);
        codes = put(codes, 9, 4'd3);
        codes = put(codes, 12, 4'd1);
        load(codes, 4'd1, 16'h1204);
        sw_pulse = 1; cyc(); sw_pulse = 0;
        chk("R5 busy after trigger", 32'(scan_busy), 1);
        chk("R4 ch12 direct on pulse", 32'(req), 32'h1000);
        cyc();
        chk("R5 first member ch2", 32'(req), 32'h0004);
        cyc();
        chk("R5 waits for done", 32'(req), 0);
        sw_pulse = 1; cyc(); sw_pulse = 0;
        chk("R8 trigger while busy", 32'(req), 32'h1000);
        cyc();
        chk("R5 still waiting", 32'(req), 0);
        conv_done = 1; cyc(); conv_done = 0;
        chk("R5 gap after done", 32'(req), 0);
        cyc();
        chk("R4 R5 second member ch9", 32'(req), 32'h0200);
        chk("R7 no eos mid scan", 32'(eos_flag), 0);
        conv_done = 1; cyc(); conv_done = 0;
        chk("R7 eos after last done", 32'(eos_flag), 1);
        chk("R5 idle after last", 32'(scan_busy), 0);
        cyc(); cyc();
        chk("R7 eos sticky", 32'(eos_flag), 1);
        chk("R8 no queued rescan", 32'(scan_busy), 0);
        chk("R8 no queued request", 32'(req), 0);
        eos_clr = 1; cyc(); eos_clr = 0;
        chk("R7 eos cleared", 32'(eos_flag), 0);

        // R6 empty scan with simultaneous clear
        load(codes, 4'd4, 16'h0000);
        sync_tick = 1; eos_clr = 1; cyc(); sync_tick = 0; eos_clr = 0;
        chk("R6 empty scan sets eos", 32'(eos_flag), 1);
        chk("R6 empty scan not busy", 32'(scan_busy), 0);
        eos_clr = 1; cyc(); eos_clr = 0;

        // R9 reserved and none scan sources
        for (int s = 0; s < 4; s += 3) begin
            load('0, 4'(s), 16'h0000);
            sw_pulse = 1; sw_level = 1; sync_tick = 1; evt = '1;
            cyc(); idle_in();
            chk("R9 no scan from code", 32'(eos_flag), 0);
        end

        // R10 enable drop aborts scan
        load(codes, 4'd6, 16'h0204);
        evt[1] = 1; cyc(); evt = '0;
        cyc();
        chk("R5 evt scan first member", 32'(req), 32'h0004);
        enable = 0; cyc();
        chk("R10 disabled quiet", 32'(req), 0);
        chk("R10 scan abandoned", 32'(scan_busy), 0);
        enable = 1; conv_done = 1; cyc(); conv_done = 0; cyc();
        chk("R10 no resume", 32'(req), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule